// File: doc/BRIEF.md
# Character Row Vertical Timing Controller

This block drives the vertical side of a character overlay. It counts horizontal line strobes after each leading edge of the vertical sync and tells the rest of the overlay, for every scan line, whether a character row is being shown, which of the memory rows it is, and which of the 16 font lines belongs on that scan line.

The first displayed line comes a programmable number of lines after the sync edge. The delay is four lines per step of the delay input, plus one line. A 6-bit height input stretches the 16-line font so that one character row covers that many scan lines. A per-row flag gives a memory row double height, so the row fills two screen row slots and the rows after it move down. After the last memory row the block stays dark until the next sync edge. A new sync edge restarts the sequence at once, even partway through the displayed rows.

All outputs change only on a clock that carries a line strobe or a sync edge. They hold steady between lines.

Top module: `char_row_vtiming`

## Requirements
- R1: After synchronous reset, row_active is 0, mem_row is 0 and font_line is 0.
- R2: With vsync_pol = 0 the leading edge is a high-to-low transition of vsync_in. With vsync_pol = 1 it is a low-to-high transition. The opposite transition has no effect on the outputs.
- R3: With delay input V, the outputs stay inactive for line strobes 1 to 4V of the frame. Strobe number 4V+1 after the leading edge shows memory row 0, font line 0, with row_active = 1. Outputs update on the clock of the strobe.
- R4: In a normal-height row with height H (16 to 63), the n-th scan line of the row (n from 0) shows font line floor(n*16/H).
- R5: A normal-height row lasts exactly H line strobes. On the next strobe mem_row goes up by one and font_line returns to 0.
- R6: A row whose bit row_dbl[mem_row] is 1 uses height 2H. It shows font line floor(n*16/(2H)) and lasts 2H strobes. The next memory row follows directly after it.
- R7: When the last memory row (row 9 by default) has finished, row_active, mem_row and font_line go to 0 and stay there until the next leading edge.
- R8: A leading edge forces row_active, mem_row and font_line to 0 on its clock, even during display. The start delay of R3 then counts again from this edge.
- R9: On a clock with no line strobe and no leading edge, none of the three outputs changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_stb | input | 1 | One-cycle pulse per horizontal scan line |
| vsync_in | input | 1 | Vertical sync input |
| vsync_pol | input | 1 | Sync polarity: 0 = active low, 1 = active high |
| vdelay | input | VD_W (8) | Vertical start delay in 4-line steps (must not be 0) |
| char_height | input | CH_W (6) | Scan lines per character row (16 to 63) |
| row_dbl | input | ROWS (10) | Double-height flag, one bit per memory row |
| row_active | output | 1 | A character row is displayed on this scan line |
| mem_row | output | $clog2(ROWS) (4) | Memory row index being displayed |
| font_line | output | 4 | Font line 0 to 15 for this scan line |

## Verification
The bench compares every scan line of each frame against a line-by-line model. That model exposes a start delay that is off by one, because the first line would show at strobe 4V or 4V+2. It also exposes a font mapping that rounds instead of truncating, or that repeats the wrong lines, most visibly at the extreme heights 16 and 126. A double-height row that does not shift the following rows down shows the wrong mem_row on every later line.

Directed frames cover a sync edge arriving in the middle of the display, where a design that does not restart would keep counting rows. They also cover the trailing sync transition, where a design keyed to the wrong edge would restart in the middle of a frame. The lines after the last row are checked too, where a design that wraps to row 0 would show stray characters. Every line also gets a second sample taken two idle clocks later, to catch outputs that move without a strobe.

// File: rtl/crv_pkg.sv
package crv_pkg;
    // Fixed font geometry: the stored glyph is 16 lines tall.
    localparam int FONT_LINES = 16;
    localparam int FONT_W     = 4;

    // Number of lines the start counter skips for a delay code v:
    // four per step. The extra line comes from the strobe that starts display.
    function automatic int lead_lines(input int v);
        return 4 * v;
    endfunction
endpackage

// File: rtl/crv_sync_detect.sv
module crv_sync_detect (
    input  logic clk,
    input  logic rst,
    input  logic vs_in,
    input  logic vs_pol,
    output logic vs_edge
);
    logic lvl;
    logic lvl_q;

    // Normalise the sync to "1 = asserted" before looking for the rise.
    assign lvl = vs_pol ? vs_in : ~vs_in;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign vs_edge = lvl & ~lvl_q;
endmodule

// File: rtl/crv_start_delay.sv
module crv_start_delay #(
    parameter  int VD_W  = 8,
    localparam int CNT_W = VD_W + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vs_edge,
    input  logic            line_stb,
    input  logic [VD_W-1:0] vdelay,
    output logic            start
);
    import crv_pkg::*;

    logic             armed;
    logic [CNT_W-1:0] seen;
    logic [CNT_W-1:0] target;

    assign target = CNT_W'(lead_lines(int'(vdelay)));
    assign start  = armed & line_stb & ~vs_edge & (seen == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            seen  <= '0;
        end else if (vs_edge) begin
            armed <= 1'b1;
            seen  <= '0;
        end else if (start) begin
            armed <= 1'b0;
        end else if (armed && line_stb) begin
            seen <= seen + 1'b1;
        end
    end

    // R3
    wait_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (vs_edge) |=> (armed && seen == '0))
        else $error("start counter not rearmed by sync edge");
endmodule

// File: rtl/crv_row_scan.sv
module crv_row_scan #(
    parameter  int ROWS  = 10,
    parameter  int CH_W  = 6,
    localparam int ROW_W = $clog2(ROWS),
    localparam int LIR_W = CH_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vs_edge,
    input  logic             start,
    input  logic             line_stb,
    input  logic [CH_W-1:0]  char_height,
    input  logic [ROWS-1:0]  row_dbl,
    output logic             row_active,
    output logic [ROW_W-1:0] mem_row,
    output logic [3:0]       font_line
);
    import crv_pkg::*;

    typedef struct packed {
        logic             active;
        logic [ROW_W-1:0] row;
        logic [LIR_W-1:0] lir;
        logic [LIR_W-1:0] rem;
        logic [FONT_W-1:0] font;
    } scan_t;

    scan_t            cur;
    scan_t            nxt;
    logic             dbl_now;
    logic [LIR_W-1:0] eff_h;
    logic [LIR_W:0]   sum;
    logic             bump;
    logic             row_end;
    logic             last_row;

    always_comb begin
        dbl_now  = (int'(cur.row) < ROWS) ? row_dbl[cur.row] : 1'b0;
        eff_h    = dbl_now ? {char_height, 1'b0} : {1'b0, char_height};
        sum      = {1'b0, cur.rem} + (LIR_W+1)'(FONT_LINES);
        bump     = sum >= {1'b0, eff_h};
        row_end  = cur.lir == (eff_h - 1'b1);
        last_row = cur.row == ROW_W'(ROWS - 1);

        nxt = cur;
        if (vs_edge) begin
            nxt = '0;
        end else if (start) begin
            nxt        = '0;
            nxt.active = 1'b1;
        end else if (cur.active && line_stb) begin
            if (row_end) begin
                nxt.lir  = '0;
                nxt.rem  = '0;
                nxt.font = '0;
                if (last_row) begin
                    nxt.active = 1'b0;
                    nxt.row    = '0;
                end else begin
                    nxt.row = cur.row + 1'b1;
                end
            end else begin
                nxt.lir = cur.lir + 1'b1;
                if (bump) begin
                    nxt.font = cur.font + 1'b1;
                    nxt.rem  = LIR_W'(sum - {1'b0, eff_h});
                end else begin
                    nxt.rem = LIR_W'(sum);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign row_active = cur.active;
    assign mem_row    = cur.row;
    assign font_line  = cur.font;

    // R9
    hold_between_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_stb && !vs_edge) |=> ($stable(row_active) && $stable(mem_row) && $stable(font_line)))
        else $error("outputs moved without a line strobe");

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
        vs_edge |=> (!row_active && mem_row == '0 && font_line == '0))
        else $error("sync edge did not clear the scan");

    // R4
    font_step_chk: assert property (@(posedge clk) disable iff (rst)
        (row_active && line_stb && !vs_edge) |=>
            (!row_active || mem_row != $past(mem_row) ||
             font_line == $past(font_line) || font_line == $past(font_line) + 1'b1))
        else $error("font line skipped within a row");

    // R7
    row_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        row_active |-> (int'(mem_row) < ROWS))
        else $error("memory row past the last row");
endmodule

// File: rtl/char_row_vtiming.sv
module char_row_vtiming #(
    parameter  int ROWS  = 10,
    parameter  int VD_W  = 8,
    parameter  int CH_W  = 6,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_stb,
    input  logic             vsync_in,
    input  logic             vsync_pol,
    input  logic [VD_W-1:0]  vdelay,
    input  logic [CH_W-1:0]  char_height,
    input  logic [ROWS-1:0]  row_dbl,
    output logic             row_active,
    output logic [ROW_W-1:0] mem_row,
    output logic [3:0]       font_line
);
    logic vs_edge;
    logic start;

    crv_sync_detect u_sync (
        .clk     (clk),
        .rst     (rst),
        .vs_in   (vsync_in),
        .vs_pol  (vsync_pol),
        .vs_edge (vs_edge)
    );

    crv_start_delay #(.VD_W(VD_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .vs_edge  (vs_edge),
        .line_stb (line_stb),
        .vdelay   (vdelay),
        .start    (start)
    );

    crv_row_scan #(.ROWS(ROWS), .CH_W(CH_W)) u_scan (
        .clk         (clk),
        .rst         (rst),
        .vs_edge     (vs_edge),
        .start       (start),
        .line_stb    (line_stb),
        .char_height (char_height),
        .row_dbl     (row_dbl),
        .row_active  (row_active),
        .mem_row     (mem_row),
        .font_line   (font_line)
    );

    // R3
    display_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(row_active) |-> ($past(line_stb) && mem_row == '0 && font_line == '0))
        else $error("display began off a line strobe or not at row 0");
endmodule

// File: tb/char_row_vtiming_test.sv
module char_row_vtiming_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_stb = 1'b0;
    logic       vsync_in = 1'b1;
    logic       vsync_pol = 1'b0;
    logic [7:0] vdelay = 8'd4;
    logic [5:0] char_height = 6'd16;
    logic [9:0] row_dbl = '0;
    logic       row_active;
    logic [3:0] mem_row;
    logic [3:0] font_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    char_row_vtiming uut (
        .clk(clk), .rst(rst), .line_stb(line_stb), .vsync_in(vsync_in),
        .vsync_pol(vsync_pol), .vdelay(vdelay), .char_height(char_height),
        .row_dbl(row_dbl), .row_active(row_active), .mem_row(mem_row),
        .font_line(font_line)
    );

    function automatic logic [8:0] expect_at(int k, int d, int ch, logic [9:0] dbl);
        int n;
        int h;
        if (k < d) return 9'd0;
        n = k - d;
        for (int r = 0; r < 10; r++) begin
            h = dbl[r] ? 2 * ch : ch;
            if (n < h) return {1'b1, 4'(r), 4'((n * 16) / h)};
            n = n - h;
        end
        return 9'd0;
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got act=%0b row=%0d font=%0d, expected act=%0b row=%0d font=%0d",
                     req, act[8], act[7:4], act[3:0], exp[8], exp[7:4], exp[3:0]);
        end
    endtask

    function automatic logic [8:0] outs();
        return {row_active, mem_row, font_line};
    endfunction

    task automatic pulse_line(input string req, input logic [8:0] exp);
        logic [8:0] first;
        @(negedge clk) line_stb = 1'b1;
        @(negedge clk) line_stb = 1'b0;
        first = outs();
        check(req, first, exp);
        repeat (2) @(negedge clk);
        check("R9", outs(), first);
    endtask

    task automatic run_frame(input int v, input int ch, input logic [9:0] dbl,
                             input logic pol, input int maxk);
        int d;
        int total;
        int lim;
        logic [8:0] e;
        string tag;
        d = v * 4 + 1;
        total = d;
        for (int r = 0; r < 10; r++) total += dbl[r] ? 2 * ch : ch;
        lim = (maxk > 0) ? maxk : total + 3;
        @(negedge clk);
        vsync_pol = pol; vdelay = 8'(v); char_height = 6'(ch); row_dbl = dbl;
        vsync_in = pol ? 1'b0 : 1'b1;
        @(negedge clk) vsync_in = pol ? 1'b1 : 1'b0;
        @(negedge clk);
        check("R8", outs(), 9'd0);
        for (int k = 1; k <= lim; k++) begin
            if (k == d + 3) vsync_in = pol ? 1'b0 : 1'b1;   // trailing transition, R2
            e = expect_at(k, d, ch, dbl);
            if (k < d)               tag = "R3";
            else if (k == d)         tag = "R3";
            else if (!e[8])          tag = "R7";
            else if (dbl[e[7:4]])    tag = "R6";
            else if (e[3:0] == 4'd0) tag = "R5";
            else                     tag = "R4";
            if (k == d + 4) tag = "R2";
            pulse_line(tag, e);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", outs(), 9'd0);
        pulse_line("R1", 9'd0);      // no edge yet: stays dark

        run_frame(1, 16, 10'b0, 1'b0, 0);            // font line = scan line
        run_frame(2, 63, 10'b11_1111_1111, 1'b1, 0); // max height, all double, active-high sync
        run_frame(1, 22, 10'b00_0010_0101, 1'b1, 0);
        run_frame(3, 25, 10'b10_0000_0001, 1'b0, 60); // cut short by next edge
        run_frame(1, 34, 10'b01_0100_0010, 1'b0, 0);  // restart mid display, R8

        void'($urandom(32'd1234));
        for (int i = 0; i < 6; i++) begin
            int v;
            int ch;
            logic [9:0] dbl;
            v   = 1 + int'($urandom % 8);
            ch  = 16 + int'($urandom % 48);
            dbl = 10'($urandom);
            run_frame(v, ch, dbl, 1'($urandom), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule